// File: doc/BRIEF.md
# Arithmetic Status Flag Generator

This block derives the six arithmetic status flags of an add or subtract from values an adder has already produced. It receives both operands, the result word, the adder's per-bit carry-out vector and an operation size of 8, 16 or 32 bits. It returns carry, auxiliary carry, parity, zero, sign and overflow. An add/subtract select tells the block whether the carry chain belongs to `a + b` or to `a + ~b + 1`. For subtraction the carry and auxiliary outputs report borrows.

Carry, overflow, sign and zero follow the selected width. Parity and auxiliary carry do not: parity always looks at the low result byte, and auxiliary carry always looks at bit 3. Nothing above the selected width reaches any flag. The parameter `REG_OUT` selects between a purely combinational output and an output held in one register stage. The register stage clears on a synchronous active-high reset.

Top module: `arith_flag_gen`

## Requirements
- R1: On an add (`op_sub`=0), `flag_carry` equals `carry_chain[t]`, where t is bit 7, 15 or 31 for `op_size` 2'b00, 2'b01 or 2'b10. This is the carry out of the top bit of the selected width.
- R2: On a subtract (`op_sub`=1), `carry_chain` comes from the adder computing `a + ~b + 1`. `flag_carry` is the borrow into the top bit, which is 1 exactly when the width-masked `op_a` is below the width-masked `op_b`.
- R3: `flag_ovf` is 1 exactly when the signed result at the selected width overflows. This is the case when the carry into bit t differs from the carry out of bit t.
- R4: At every size, `flag_aux` is the carry out of bit 3 on an add and the borrow into bit 3 on a subtract.
- R5: At every size, `flag_parity` is 1 exactly when `result[7:0]` holds an even number of ones.
- R6: `flag_zero` is 1 exactly when all result bits within the selected width are 0.
- R7: `flag_sign` equals `result[t]`.
- R8: Bits of `result`, `carry_chain` and the operands above the selected width do not change any flag.
- R9: `op_size` 2'b11 behaves exactly like 2'b10 (32-bit).
- R10: With `REG_OUT`=1, the flags appear one clock after their inputs, and they read 0 in the cycle after a clock edge with `rst` high. With `REG_OUT`=0, the flags follow the inputs with no clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset of the output register |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand (subtrahend on subtract) |
| result | input | 32 | Adder result word |
| carry_chain | input | 32 | Carry out of each adder bit position |
| op_sub | input | 1 | 0 = add, 1 = subtract |
| op_size | input | 2 | 00 = 8-bit, 01 = 16-bit, 10/11 = 32-bit |
| flag_carry | output | 1 | Carry / borrow at the top bit |
| flag_aux | output | 1 | Carry / borrow at bit 3 |
| flag_parity | output | 1 | Even parity of the low result byte |
| flag_zero | output | 1 | Result zero within the selected width |
| flag_sign | output | 1 | Top bit of the selected width |
| flag_ovf | output | 1 | Signed overflow |

## Verification
Two copies of the block are checked side by side. In the combinational copy the flags are valid within the cycle in which the inputs change. In the registered copy they are due one rising edge later. The bench changes inputs on a falling edge and waits through exactly one rising edge. It then samples both copies on the next falling edge, so each copy is read after its own latency and before the inputs move again. The reset check samples the falling edge that follows a rising edge taken with `rst` high.

// File: rtl/afg_pkg.sv
package afg_pkg;
    localparam int unsigned DATA_W = 32;
    localparam int unsigned IDX_W  = $clog2(DATA_W);
    localparam int unsigned NIB_HI = 4;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_ALT  = 2'b11
    } afg_size_e;

    typedef struct packed {
        logic ovf;
        logic sign;
        logic zero;
        logic parity;
        logic aux;
        logic carry;
    } afg_flags_t;

    function automatic logic [IDX_W-1:0] afg_top(input logic [1:0] sz);
        case (sz)
            SZ_BYTE: afg_top = IDX_W'(7);
            SZ_HALF: afg_top = IDX_W'(15);
            default: afg_top = IDX_W'(DATA_W - 1);
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] afg_mask(input logic [1:0] sz);
        case (sz)
            SZ_BYTE: afg_mask = DATA_W'(32'h0000_00FF);
            SZ_HALF: afg_mask = DATA_W'(32'h0000_FFFF);
            default: afg_mask = {DATA_W{1'b1}};
        endcase
    endfunction
endpackage

// File: rtl/afg_wide_flags.sv
module afg_wide_flags
    import afg_pkg::*;
(
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_eff_i,
    input  logic [DATA_W-1:0] res_i,
    input  logic [DATA_W-1:0] chain_i,
    input  logic              sub_i,
    input  logic [1:0]        size_i,
    output logic              carry_o,
    output logic              ovf_o,
    output logic              sign_o,
    output logic              zero_o
);
    logic [IDX_W-1:0]  top;
    logic [DATA_W-1:0] cin_vec;
    logic [DATA_W-1:0] in_width;

    always_comb begin
        top      = afg_top(size_i);
        cin_vec  = a_i ^ b_eff_i ^ res_i;
        in_width = res_i & afg_mask(size_i);
        carry_o  = chain_i[top] ^ sub_i;
        ovf_o    = cin_vec[top] ^ chain_i[top];
        sign_o   = res_i[top];
        zero_o   = (in_width == '0);
    end
endmodule

// File: rtl/afg_byte_flags.sv
module afg_byte_flags
    import afg_pkg::*;
(
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_eff_i,
    input  logic [DATA_W-1:0] res_i,
    input  logic              sub_i,
    output logic              parity_o,
    output logic              aux_o
);
    always_comb begin
        parity_o = ~(^res_i[7:0]);
        aux_o    = a_i[NIB_HI] ^ b_eff_i[NIB_HI] ^ res_i[NIB_HI] ^ sub_i;
    end
endmodule

// File: rtl/arith_flag_gen.sv
module arith_flag_gen
    import afg_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    input  logic [DATA_W-1:0] result,
    input  logic [DATA_W-1:0] carry_chain,
    input  logic              op_sub,
    input  logic [1:0]        op_size,
    output logic              flag_carry,
    output logic              flag_aux,
    output logic              flag_parity,
    output logic              flag_zero,
    output logic              flag_sign,
    output logic              flag_ovf
);
    logic [DATA_W-1:0] b_eff;
    afg_flags_t        comb_f;
    afg_flags_t        out_f;

    assign b_eff = op_sub ? ~op_b : op_b;

    afg_wide_flags u_wide (
        .a_i     (op_a),
        .b_eff_i (b_eff),
        .res_i   (result),
        .chain_i (carry_chain),
        .sub_i   (op_sub),
        .size_i  (op_size),
        .carry_o (comb_f.carry),
        .ovf_o   (comb_f.ovf),
        .sign_o  (comb_f.sign),
        .zero_o  (comb_f.zero)
    );

    afg_byte_flags u_byte (
        .a_i      (op_a),
        .b_eff_i  (b_eff),
        .res_i    (result),
        .sub_i    (op_sub),
        .parity_o (comb_f.parity),
        .aux_o    (comb_f.aux)
    );

    generate
        if (REG_OUT) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst) out_f <= '0;
                else     out_f <= comb_f;
            end

            // R10
            out_reset_chk: assert property (@(posedge clk)
                rst |=> (out_f == '0));

            // R10
            out_delay_chk: assert property (@(posedge clk) disable iff (rst)
                1'b1 |=> (out_f == $past(comb_f)));
        end else begin : g_comb
            assign out_f = comb_f;
        end
    endgenerate

    assign flag_carry  = out_f.carry;
    assign flag_aux    = out_f.aux;
    assign flag_parity = out_f.parity;
    assign flag_zero   = out_f.zero;
    assign flag_sign   = out_f.sign;
    assign flag_ovf    = out_f.ovf;

    // R6
    zero_not_neg_chk: assert property (@(posedge clk) disable iff (rst)
        comb_f.zero |-> !comb_f.sign);

    // R5
    byte_zero_par_chk: assert property (@(posedge clk) disable iff (rst)
        (op_size == SZ_BYTE && comb_f.zero) |-> comb_f.parity);

    // R3
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        (!op_sub && op_a[afg_top(op_size)] != op_b[afg_top(op_size)])
            |-> !comb_f.ovf);

    // R3
    sub_same_sign_chk: assert property (@(posedge clk) disable iff (rst)
        (op_sub && op_a[afg_top(op_size)] == op_b[afg_top(op_size)])
            |-> !comb_f.ovf);
endmodule

// File: tb/arith_flag_gen_tb_top.sv
`timescale 1ns/1ps
module arith_flag_gen_tb_top;
    localparam int NV = 14;
    localparam logic [31:0] VA [NV] = '{
        32'h0000_007F, 32'h0000_00FF, 32'h0000_0000, 32'h0000_0080,
        32'h0000_7FFF, 32'h1234_FFFF, 32'h0000_8000, 32'hFFFF_FFFF,
        32'h7FFF_FFFF, 32'h0000_0000, 32'h8000_0000, 32'h1234_5678,
        32'hFFFF_FF7F, 32'h0000_0005};
    localparam logic [31:0] VB [NV] = '{
        32'h1, 32'h1, 32'h1, 32'h1, 32'h1, 32'h1, 32'h1, 32'h1,
        32'h1, 32'h1, 32'h8000_0000, 32'h1234_5678, 32'h1, 32'h9};
    localparam logic VS [NV] = '{0,0,1,1, 0,0,1,0, 0,1,0,1, 0,1};
    localparam logic [1:0] VZ [NV] = '{0,0,0,0, 1,1,1,2, 2,2,2,2, 3,3};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] a = '0, b = '0, r = '0, ch = '0;
    logic        sub = 1'b0;
    logic [1:0]  sz = '0;
    logic        rc, ra, rp, rz, rs, ro;
    logic        cc, ca, cp, cz, cs, co;
    int          total = 0;
    int          bad = 0;

    always #4 clk = ~clk;

    arith_flag_gen #(.REG_OUT(1'b1)) dut_i (
        .clk(clk), .rst(rst), .op_a(a), .op_b(b), .result(r),
        .carry_chain(ch), .op_sub(sub), .op_size(sz),
        .flag_carry(rc), .flag_aux(ra), .flag_parity(rp),
        .flag_zero(rz), .flag_sign(rs), .flag_ovf(ro));

    arith_flag_gen #(.REG_OUT(1'b0)) comb_i (
        .clk(clk), .rst(rst), .op_a(a), .op_b(b), .result(r),
        .carry_chain(ch), .op_sub(sub), .op_size(sz),
        .flag_carry(cc), .flag_aux(ca), .flag_parity(cp),
        .flag_zero(cz), .flag_sign(cs), .flag_ovf(co));

    // 32-bit ripple adder producing the stimulus result and carry chain
    task automatic run_adder(input logic [31:0] x, input logic [31:0] y,
                             input logic s, output logic [31:0] sum,
                             output logic [31:0] cv);
        logic c = s;
        for (int i = 0; i < 32; i++) begin
            logic yb = s ? ~y[i] : y[i];
            sum[i] = x[i] ^ yb ^ c;
            c      = (x[i] & yb) | (x[i] & c) | (yb & c);
            cv[i]  = c;
        end
    endtask

    // expected {ovf,sign,zero,parity,aux,carry} from arithmetic definitions
    function automatic logic [5:0] model(input logic [31:0] x, input logic [31:0] y,
                                         input logic s, input logic [1:0] z);
        int w = (z == 2'b00) ? 8 : (z == 2'b01) ? 16 : 32;
        logic [32:0] m = (33'h1 << w) - 33'h1;
        logic [32:0] xm = {1'b0, x} & m;
        logic [32:0] ym = {1'b0, y} & m;
        logic [32:0] full = s ? (xm - ym) : (xm + ym);
        logic [32:0] rm = full & m;
        logic sx = xm[w-1], sy = ym[w-1], sr = rm[w-1];
        logic fc = s ? (xm < ym) : full[w];
        logic fa = s ? (x[3:0] < y[3:0]) : ((5'(x[3:0]) + 5'(y[3:0])) > 5'd15);
        logic fo = s ? (sx != sy && sr != sx) : (sx == sy && sr != sx);
        logic fz = (rm == '0);
        logic [31:0] rr = rm[31:0];
        logic fp = ~(^rr[7:0]);
        return {fo, sr, fz, fp, fa, fc};
    endfunction

    task automatic check(input string tag, input logic [5:0] act, input logic [5:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: flags{o,s,z,p,a,c} got=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic apply(input logic [31:0] x, input logic [31:0] y, input logic s,
                         input logic [1:0] z, input logic [31:0] hi_flip,
                         input string tag);
        logic [31:0] sum, cv;
        logic [5:0]  e;
        run_adder(x, y, s, sum, cv);
        e = model(x, y, s, z);
        @(negedge clk);
        a = x; b = y; sub = s; sz = z;
        r = sum ^ hi_flip; ch = cv ^ hi_flip;
        @(posedge clk);
        @(negedge clk);
        check({tag, " comb"}, {co, cs, cz, cp, ca, cc}, e);
        check({tag, " reg"},  {ro, rs, rz, rp, ra, rc}, e);
    endtask

    initial begin : watchdog
        #(200000 * 8);
        bad++;
        $display("FAIL watchdog: run did not finish, got=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        // R10: reset clears the registered flags even with live inputs
        a = 32'h0; b = 32'h0; r = 32'h0; ch = '0; sz = 2'b10;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R10 reset", {ro, rs, rz, rp, ra, rc}, 6'b0);

        @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            string tag;
            if (VZ[i] == 2'b11)
                tag = "R9 size11";
            else if (VS[i])
                tag = "R2 R3 R4 R5 R6 R7";
            else
                tag = "R1 R3 R4 R5 R6 R7";
            apply(VA[i], VB[i], VS[i], VZ[i], 32'h0, tag);
        end

        // R8: junk above the selected width, 8-bit and 16-bit
        apply(32'hAA00_007F, 32'h5500_0001, 1'b0, 2'b00, 32'hFFFF_FF00, "R8 byte");
        apply(32'h0F00_8000, 32'h3300_8000, 1'b1, 2'b00, 32'hFFFF_FF00, "R8 byte sub");
        apply(32'h7777_FFFF, 32'h0000_0001, 1'b0, 2'b01, 32'hFFFF_0000, "R8 half");

        // R5/R4: parity and aux stay on the low byte at 32 bits
        apply(32'h0100_0008, 32'h0000_0008, 1'b0, 2'b10, 32'h0, "R4 R5 wide");

        // R10: registered copy shows reset value again after a reset edge
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R10 re-reset", {ro, rs, rz, rp, ra, rc}, 6'b0);
        rst = 1'b0;

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule